// File: doc/BRIEF.md
# Stereo Audio DAC Rate Generator and Sample Front End

This block sits between software and a stereo audio converter. A 20-bit phase accumulator, advanced once every 128 crystal-clock cycles by a 7-bit prescaler, adds a programmable rate word on each step. Every carry out of the accumulator's top bit marks one output sample period. The resulting sample rate is f_clk × rate / 2^27. Both the prescaler and the accumulator run directly on the crystal clock.

Software reaches the block through a 16-bit register port with six word registers. Two of them hold the rate word and four hold the 24-bit left and right samples. On each sample strobe the pending samples of both channels move together into output holding registers, and a sticky interrupt asks software for the next pair. A rate word of zero puts the block in idle: the prescaler and accumulator stop, and the enable for the analog clock goes low.

Top module: `dacfe_top`

## Requirements
- R1: All six registers (offset 0 rate low, 1 rate high, 2 left low byte, 3 left high word, 4 right low byte, 5 right high word) are read/write and read zero after reset. Reads of offsets 6 and 7 return zero, and so does any cycle without a read.
- R2: The rate word is {offset1[3:0], offset0[15:0]}. Bits 15..4 of offset 1 are not stored and read as zero.
- R3: A channel's sample is {high word[15:0], low-byte register[15:8]}. Bits 7..0 of a low-byte register are not stored and read as zero.
- R4: While the rate word is zero, no sample strobe occurs, the prescaler and accumulator hold, and `aclk_en` is low. `aclk_en` is high whenever the rate word is non-zero.
- R5: After K accumulation steps from a zero accumulator, exactly floor(K × rate / 2^20) one-cycle strobes have been produced. The steps are spaced 128 clock cycles apart.
- R6: On a strobe taken while the interrupt is clear, both `left_out` and `right_out` change in the same cycle to the pending samples.
- R7: The interrupt `irq` goes high in the same cycle as every strobe.
- R8: A write to offset 3 clears `irq` on the next cycle. When a strobe arrives in the same cycle as that write, setting the interrupt wins.
- R9: A strobe that arrives while `irq` is still set leaves both outputs unchanged, so the previous pair repeats.
- R10: Changing the rate word keeps the accumulator value. Writing zero clears the prescaler, and the next non-zero word starts a full 128-cycle step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| smp_strobe | output | 1 | One-cycle sample strobe |
| left_out | output | 24 | Held left sample |
| right_out | output | 24 | Held right sample |
| aclk_en | output | 1 | Analog clock enable |
| irq | output | 1 | Sample request interrupt |

## Verification
The rate generator is tried with several rate words. 0x80000 and 0x40000 divide 2^20 evenly, so they reveal an error in step spacing. 0xFFFFF and 0x55555 leave a remainder, which separates truncation from rounding. Rate words of 1 and 0x10000 exercise the low and high register halves on their own. A rate sequence of 0xC0000, then zero, then 0x40000 must produce a strobe on the first new step, which shows that the accumulator value survives idle. A sample sequence that skips the interrupt acknowledge must repeat the old pair, and a later acknowledge must let the new pair through.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int unsigned BUS_AW = 3;
  localparam int unsigned BUS_DW = 16;

  typedef enum logic [BUS_AW-1:0] {
    OFS_RATE_LO = 3'd0,
    OFS_RATE_HI = 3'd1,
    OFS_L_LO    = 3'd2,
    OFS_L_HI    = 3'd3,
    OFS_R_LO    = 3'd4,
    OFS_R_HI    = 3'd5
  } reg_ofs_e;
endpackage

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
#(
  parameter int unsigned ACC_W = 20,
  parameter int unsigned SMP_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [BUS_AW-1:0] addr,
  input  logic [BUS_DW-1:0] wdata,
  output logic [BUS_DW-1:0] rdata,
  output logic [ACC_W-1:0]  rate,
  output logic [SMP_W-1:0]  left_pend,
  output logic [SMP_W-1:0]  right_pend,
  output logic              ack_wr
);
  localparam int unsigned RHI_W = ACC_W - BUS_DW;
  localparam int unsigned LO_W  = SMP_W - BUS_DW;

  logic [BUS_DW-1:0] rlo_q, lhi_q, rhi_q;
  logic [RHI_W-1:0]  rhigh_q;
  logic [LO_W-1:0]   llo_q, rlo8_q;

  logic wen_rlo, wen_rhi, wen_llo, wen_lhi, wen_r8, wen_rh;
  logic [BUS_DW-1:0] rd_mux;

  always_comb begin
    wen_rlo = sel && wr && (addr == OFS_RATE_LO);
    wen_rhi = sel && wr && (addr == OFS_RATE_HI);
    wen_llo = sel && wr && (addr == OFS_L_LO);
    wen_lhi = sel && wr && (addr == OFS_L_HI);
    wen_r8  = sel && wr && (addr == OFS_R_LO);
    wen_rh  = sel && wr && (addr == OFS_R_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rlo_q   <= '0;
      rhigh_q <= '0;
      llo_q   <= '0;
      lhi_q   <= '0;
      rlo8_q  <= '0;
      rhi_q   <= '0;
    end else begin
      if (wen_rlo) rlo_q   <= wdata;
      if (wen_rhi) rhigh_q <= wdata[RHI_W-1:0];
      if (wen_llo) llo_q   <= wdata[BUS_DW-1 -: LO_W];
      if (wen_lhi) lhi_q   <= wdata;
      if (wen_r8)  rlo8_q  <= wdata[BUS_DW-1 -: LO_W];
      if (wen_rh)  rhi_q   <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_RATE_LO: rd_mux = rlo_q;
      OFS_RATE_HI: rd_mux[RHI_W-1:0] = rhigh_q;
      OFS_L_LO:    rd_mux[BUS_DW-1 -: LO_W] = llo_q;
      OFS_L_HI:    rd_mux = lhi_q;
      OFS_R_LO:    rd_mux[BUS_DW-1 -: LO_W] = rlo8_q;
      OFS_R_HI:    rd_mux = rhi_q;
      default:     rd_mux = '0;
    endcase
    rdata = (sel && !wr) ? rd_mux : '0;
  end

  assign rate       = {rhigh_q, rlo_q};
  assign left_pend  = {lhi_q, llo_q};
  assign right_pend = {rhi_q, rlo8_q};
  assign ack_wr     = wen_lhi;

  AST_RATE_HI_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_rhi && !wen_rlo) |=> (rate[BUS_DW-1:0] == $past(rate[BUS_DW-1:0]))); // R2
endmodule

// File: rtl/dacfe_rate_core.sv
module dacfe_rate_core #(
  parameter int unsigned ACC_W = 20,
  parameter int unsigned PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] rate,
  output logic             roll,
  output logic             strobe,
  output logic             aclk_en
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;
  logic             run, step, strobe_d;

  always_comb begin
    run      = |rate;
    step     = run && (pre_q == {PRE_W{1'b1}});
    pre_d    = run ? (pre_q + 1'b1) : '0;
    sum      = {1'b0, acc_q} + {1'b0, rate};
    acc_d    = step ? sum[ACC_W-1:0] : acc_q;
    roll     = step && sum[ACC_W];
    strobe_d = roll;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      acc_q  <= '0;
      strobe <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      if (step) acc_q <= acc_d;
      strobe <= strobe_d;
    end
  end

  assign aclk_en = run;

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == '0) |=> !strobe); // R4
  AST_IDLE_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == '0) |=> $stable(acc_q)); // R4
  AST_IDLE_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == '0) |=> (pre_q == '0)); // R10
endmodule

// File: rtl/dacfe_hold.sv
module dacfe_hold #(
  parameter int unsigned SMP_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             roll,
  input  logic             ack,
  input  logic [SMP_W-1:0] left_pend,
  input  logic [SMP_W-1:0] right_pend,
  output logic [SMP_W-1:0] left_out,
  output logic [SMP_W-1:0] right_out,
  output logic             irq
);
  logic copy, irq_d;

  always_comb begin
    copy  = roll && !irq;
    irq_d = roll ? 1'b1 : (ack ? 1'b0 : irq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_out  <= '0;
      right_out <= '0;
      irq       <= 1'b0;
    end else begin
      if (copy) begin
        left_out  <= left_pend;
        right_out <= right_pend;
      end
      irq <= irq_d;
    end
  end

  AST_REPEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (roll && irq) |=> ($stable(left_out) && $stable(right_out))); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !roll) |=> !irq); // R8
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int unsigned ACC_W = 20,
  parameter int unsigned PRE_W = 7,
  parameter int unsigned SMP_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              smp_strobe,
  output logic [SMP_W-1:0]  left_out,
  output logic [SMP_W-1:0]  right_out,
  output logic              aclk_en,
  output logic              irq
);
  logic [ACC_W-1:0] rate;
  logic [SMP_W-1:0] left_pend, right_pend;
  logic             ack_wr, roll;

  dacfe_regs #(.ACC_W(ACC_W), .SMP_W(SMP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .rate(rate),
    .left_pend(left_pend), .right_pend(right_pend), .ack_wr(ack_wr)
  );

  dacfe_rate_core #(.ACC_W(ACC_W), .PRE_W(PRE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .rate(rate), .roll(roll),
    .strobe(smp_strobe), .aclk_en(aclk_en)
  );

  dacfe_hold #(.SMP_W(SMP_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .roll(roll), .ack(ack_wr),
    .left_pend(left_pend), .right_pend(right_pend),
    .left_out(left_out), .right_out(right_out), .irq(irq)
  );

  AST_STROBE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe |-> irq); // R7
endmodule

// File: tb/sim_dacfe_top.sv
`timescale 1ns/1ps
module sim_dacfe_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        smp_strobe, aclk_en, irq;
  logic [23:0] left_out, right_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  dacfe_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .smp_strobe(smp_strobe), .left_out(left_out), .right_out(right_out),
    .aclk_en(aclk_en), .irq(irq)
  );

  // rate[35:16], steps K [15:8], expected strobes [7:0]
  localparam logic [35:0] VEC [0:5] = '{
    {20'h80000, 8'd8,  8'd4},
    {20'hFFFFF, 8'd16, 8'd15},
    {20'h00001, 8'd16, 8'd0},
    {20'h40000, 8'd12, 8'd3},
    {20'h55555, 8'd12, 8'd3},
    {20'h10000, 8'd32, 8'd2}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish, act=%0d exp<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic count_str(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (smp_strobe) c++;
    end
  endtask

  task automatic wait_str(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (smp_strobe) return;
    end
  endtask

  initial begin
    logic [15:0] d;
    int c;
    rst_n = 1'b0;
    do_reset();

    // Reset state
    chk("R1 irq after reset", irq, 0);
    chk("R1 left_out after reset", left_out, 0);
    chk("R1 right_out after reset", right_out, 0);
    chk("R4 aclk_en after reset", aclk_en, 0);
    for (int a = 0; a < 6; a++) begin
      rd_reg(a[2:0], d);
      chk("R1 register reads zero after reset", d, 0);
    end

    // Field packing and readback
    wr_reg(3'd1, 16'hFFF0);
    rd_reg(3'd1, d);
    chk("R2 rate high keeps bits 3..0 only", d, 16'h0000);
    wr_reg(3'd1, 16'h0000);
    wr_reg(3'd0, 16'h0000);
    wr_reg(3'd2, 16'hABCD);
    rd_reg(3'd2, d);
    chk("R3 left low byte in bits 15..8", d, 16'hAB00);
    wr_reg(3'd5, 16'h5A5A);
    rd_reg(3'd5, d);
    chk("R1 right high readback", d, 16'h5A5A);
    rd_reg(3'd6, d);
    chk("R1 unused offset reads zero", d, 0);

    // Idle: rate zero
    count_str(600, c);
    chk("R4 no strobe while idle", c, 0);
    chk("R4 irq stays low while idle", irq, 0);
    chk("R4 aclk_en low while idle", aclk_en, 0);

    // Rate table
    for (int v = 0; v < 6; v++) begin
      logic [19:0] r;
      int k;
      r = VEC[v][35:16];
      k = int'(VEC[v][15:8]);
      do_reset();
      wr_reg(3'd0, r[15:0]);
      wr_reg(3'd1, {12'h000, r[19:16]});
      chk("R4 aclk_en high when running", aclk_en, 1);
      count_str(128 * k + 4, c);
      chk("R5 strobe count for rate word", c, {24'h0, VEC[v][7:0]});
    end

    // R2: high half alone selects bits 19..16
    do_reset();
    wr_reg(3'd1, 16'hFFF8);
    rd_reg(3'd1, d);
    chk("R2 rate high readback masked", d, 16'h0008);
    count_str(128 * 4 + 4, c);
    chk("R2 high half alone gives rate 0x80000", c, 2);

    // Sample transfer, repeat and acknowledge
    do_reset();
    wr_reg(3'd2, 16'h3400);
    wr_reg(3'd3, 16'h1256);
    wr_reg(3'd4, 16'h7800);
    wr_reg(3'd5, 16'hABCD);
    wr_reg(3'd1, 16'h0008);
    wait_str(600);
    chk("R6 left copied on strobe", left_out, 24'h125634);
    chk("R6 right copied on strobe", right_out, 24'hABCD78);
    chk("R7 irq set with strobe", irq, 1);
    wr_reg(3'd2, 16'h9900);
    wr_reg(3'd5, 16'h1111);
    wait_str(600);
    chk("R9 left repeats while irq set", left_out, 24'h125634);
    chk("R9 right repeats while irq set", right_out, 24'hABCD78);
    chk("R7 irq still set", irq, 1);
    wr_reg(3'd3, 16'h2222);
    chk("R8 irq cleared by left high write", irq, 0);
    wait_str(600);
    chk("R6 new left after acknowledge", left_out, 24'h222299);
    chk("R6 new right after acknowledge", right_out, 24'h111178);

    // Accumulator kept across idle
    do_reset();
    wr_reg(3'd1, 16'h000C);
    count_str(128 + 4, c);
    chk("R10 no roll after one step at 0xC0000", c, 0);
    wr_reg(3'd1, 16'h0000);
    chk("R4 aclk_en drops on zero rate", aclk_en, 0);
    count_str(40, c);
    chk("R4 no strobe after zero rate", c, 0);
    wr_reg(3'd1, 16'h0004);
    count_str(120, c);
    chk("R10 prescaler restarts full step", c, 0);
    count_str(12, c);
    chk("R10 accumulator kept, roll on first step", c, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule